// File: doc/BRIEF.md
# Cipher Chaining Unit

This unit sits between a streaming data path and an external 128-bit block cipher core. It keeps the chaining value for the selected mode. That value is an IV, a counter block or a tweak, depending on the mode. For each block the unit forms the word sent to the core, and then combines the core result into the final output. The unit supports electronic codebook, cipher block chaining, 128-bit cipher feedback and counter modes. It also supports a tweaked mode in which the tweak is advanced by one multiplication by x in GF(2^128) per block.

Software, or a controlling block, first presents a configuration on the load port: mode, direction, counter width and a 128-bit seed. Data blocks then stream through a valid/ready input and a valid/ready output. Only one block is in flight at a time. The unit issues a one-cycle request to the core and waits for the core's done pulse. It holds the result until the downstream side takes it.

Top module: `cipher_chain_unit`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid`, `core_req` and `load_err` are 0.
- R2: `cfg_mode` selects the mode: 0 codebook, 1 block chaining, 2 cipher feedback, 3 counter, 4 tweaked, 5 to 7 act as codebook. In codebook mode the core receives the input block unchanged, the output is the core result, and `core_decrypt` equals the loaded `cfg_decrypt` bit.
- R3: In block chaining mode with encryption, the core input is data XOR chain, and the result is both the output and the new chain value. With decryption, the core receives the data, the output is result XOR chain, and the input block becomes the new chain value.
- R4: In cipher feedback mode the core always encrypts the chain value (`core_decrypt`=0), and the output is result XOR data. The new chain value is the ciphertext: the output when encrypting, the input when decrypting.
- R5: In counter mode only the low m bits of the counter block increment, modulo 2^m, after each block. The upper bits are unchanged. `cfg_ctr_width` 0,1,2,3 gives m = 16, 32, 64, 96, and 4 to 7 give m = 128.
- R6: In counter mode the core encrypts the counter block (`core_decrypt`=0) in both directions, and the output is data XOR result.
- R7: In tweaked mode the core input is data XOR tweak, the output is result XOR tweak, and `core_decrypt` follows `cfg_decrypt`. The next tweak is the current one shifted left by one bit, XORed with 0x87 in the low byte when bit 127 was 1.
- R8: A load is taken only while no block is in flight. A load at any other time changes no configuration or chain state, and raises `load_err` for exactly the following cycle.
- R9: From input acceptance until the output is taken, `in_ready` is 0. While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value.
- R10: Each accepted block produces exactly one `core_req` pulse, one cycle wide, in the cycle after acceptance.
- R11: A load in the same cycle as `in_valid` wins. `in_ready` is 0 in that cycle, and the block then uses the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_mode | input | 3 | Mode select |
| cfg_decrypt | input | 1 | 1 selects the decrypt direction |
| cfg_ctr_width | input | 3 | Counter increment width select |
| cfg_seed | input | 128 | Initial IV, counter block or tweak |
| load_err | output | 1 | Load refused because a block was in flight |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Unit can accept a block |
| in_data | input | 128 | Input block |
| out_valid | output | 1 | Output block valid |
| out_ready | input | 1 | Downstream takes the output |
| out_data | output | 128 | Output block |
| core_req | output | 1 | One-cycle start pulse to the cipher core |
| core_decrypt | output | 1 | Direction requested from the core |
| core_text | output | 128 | Block sent to the core |
| core_done | input | 1 | Core result valid pulse |
| core_result | input | 128 | Core result |

## Verification
The assertions assume that the core answers every request with exactly one `core_done` pulse. That pulse arrives only while the unit is waiting for it, and never in the same cycle as the request. The bench's stand-in core keeps to this. It latches the request, counts a fixed latency and returns a single pulse carrying a rotate-and-XOR permutation of the latched block. It picks the forward or inverse permutation from `core_decrypt`. Configuration fields are driven only on negative edges, and `cfg_ctr_width` only changes together with a load, so the counter-width decode seen by the checks is always settled.

// File: rtl/cipher_chain_unit.sv
module cipher_chain_unit #(
  parameter int BLK_W = 128,
  parameter logic [BLK_W-1:0] RED_POLY = 'h87
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_decrypt,
  input  logic [2:0]       cfg_ctr_width,
  input  logic [BLK_W-1:0] cfg_seed,
  output logic             load_err,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BLK_W-1:0] out_data,
  output logic             core_req,
  output logic             core_decrypt,
  output logic [BLK_W-1:0] core_text,
  input  logic             core_done,
  input  logic [BLK_W-1:0] core_result
);

  localparam logic [2:0] M_CBC = 3'd1;
  localparam logic [2:0] M_CFB = 3'd2;
  localparam logic [2:0] M_CTR = 3'd3;
  localparam logic [2:0] M_XTS = 3'd4;
  localparam logic [BLK_W-1:0] ONES = '1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_OUT} state_t;

  state_t           state_q;
  logic [2:0]       mode_q, wsel_q;
  logic             dec_q, req_q, err_q;
  logic [BLK_W-1:0] chain_q, data_q, text_q, out_q;
  logic [BLK_W-1:0] text_nx, out_nx, chain_nx, ctr_mask, tweak_nx;

  function automatic logic [BLK_W-1:0] width_mask(input logic [2:0] s);
    case (s)
      3'd0:    return ONES >> (BLK_W - 16);
      3'd1:    return ONES >> (BLK_W - 32);
      3'd2:    return ONES >> (BLK_W - 64);
      3'd3:    return ONES >> (BLK_W - 96);
      default: return ONES;
    endcase
  endfunction

  assign ctr_mask = width_mask(wsel_q);
  assign tweak_nx = {chain_q[BLK_W-2:0], 1'b0} ^ (chain_q[BLK_W-1] ? RED_POLY : '0);

  assign in_ready     = (state_q == S_IDLE) && !cfg_load;
  assign out_valid    = (state_q == S_OUT);
  assign out_data     = out_q;
  assign core_req     = req_q;
  assign core_text    = text_q;
  assign load_err     = err_q;
  assign core_decrypt = dec_q && (mode_q != M_CFB) && (mode_q != M_CTR);

  always_comb begin
    case (mode_q)
      M_CBC:        text_nx = dec_q ? in_data : (in_data ^ chain_q);
      M_CFB, M_CTR: text_nx = chain_q;
      M_XTS:        text_nx = in_data ^ chain_q;
      default:      text_nx = in_data;
    endcase
  end

  always_comb begin
    out_nx   = core_result;
    chain_nx = chain_q;
    case (mode_q)
      M_CBC: begin
        out_nx   = dec_q ? (core_result ^ chain_q) : core_result;
        chain_nx = dec_q ? data_q : core_result;
      end
      M_CFB: begin
        out_nx   = core_result ^ data_q;
        chain_nx = dec_q ? data_q : (core_result ^ data_q);
      end
      M_CTR: begin
        out_nx   = core_result ^ data_q;
        chain_nx = (chain_q & ~ctr_mask) | ((chain_q + 1'b1) & ctr_mask);
      end
      M_XTS: begin
        out_nx   = core_result ^ chain_q;
        chain_nx = tweak_nx;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= '0;
      wsel_q  <= '0;
      dec_q   <= 1'b0;
      req_q   <= 1'b0;
      err_q   <= 1'b0;
      chain_q <= '0;
      data_q  <= '0;
      text_q  <= '0;
      out_q   <= '0;
    end else begin
      req_q <= 1'b0;
      err_q <= cfg_load && (state_q != S_IDLE);
      if (cfg_load && state_q == S_IDLE) begin
        mode_q  <= cfg_mode;
        dec_q   <= cfg_decrypt;
        wsel_q  <= cfg_ctr_width;
        chain_q <= cfg_seed;
      end
      case (state_q)
        S_IDLE: if (in_valid && in_ready) begin
          data_q  <= in_data;
          text_q  <= text_nx;
          req_q   <= 1'b1;
          state_q <= S_WAIT;
        end
        S_WAIT: if (core_done) begin
          out_q   <= out_nx;
          chain_q <= chain_nx;
          state_q <= S_OUT;
        end
        default: if (out_ready) state_q <= S_IDLE;
      endcase
    end
  end

  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |=> !core_req);

  // R10
  req_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> core_req);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  no_accept_while_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R8
  busy_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && state_q != S_IDLE) |=> (load_err && $stable(mode_q) && $stable(dec_q) && $stable(wsel_q)));

  // R8
  load_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |-> !$past(in_ready));

  // R5
  ctr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && core_done && mode_q == M_CTR && !cfg_load)
      |=> ((chain_q & ~ctr_mask) == ($past(chain_q) & ~ctr_mask)));

  // R10 input assumption: the core answers only while a block waits
  done_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |-> (state_q == S_WAIT && !core_req));

endmodule

// File: tb/cipher_chain_unit_tb_top.sv
`timescale 1ns/1ps
module cipher_chain_unit_tb_top;
  localparam int LAT = 4;
  localparam logic [127:0] KEY = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 0, cfg_decrypt = 0;
  logic [2:0] cfg_mode = 0, cfg_ctr_width = 0;
  logic [127:0] cfg_seed = 0, in_data = 0, core_result = 0, out_data, core_text;
  logic load_err, in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic core_req, core_decrypt, core_done = 0;
  int checks = 0, errors = 0, req_cnt = 0, cm_cnt = 0;
  logic [127:0] cm_text = 0;
  logic cm_dec = 0;

  always #2.5 clk = ~clk;

  cipher_chain_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_decrypt(cfg_decrypt), .cfg_ctr_width(cfg_ctr_width), .cfg_seed(cfg_seed),
    .load_err(load_err), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .core_req(core_req), .core_decrypt(core_decrypt), .core_text(core_text),
    .core_done(core_done), .core_result(core_result));

  function automatic logic [127:0] penc(input logic [127:0] x);
    return {x[114:0], x[127:115]} ^ KEY;
  endfunction
  function automatic logic [127:0] pdec(input logic [127:0] y);
    logic [127:0] t;
    t = y ^ KEY;
    return {t[12:0], t[127:13]};
  endfunction
  function automatic logic [127:0] gfx(input logic [127:0] t);
    return {t[126:0], 1'b0} ^ (t[127] ? 128'h87 : 128'h0);
  endfunction
  function automatic logic [127:0] ctr_inc(input logic [127:0] v, input int m);
    logic [127:0] mk;
    mk = (m >= 128) ? '1 : ((128'h1 << m) - 1);
    return (v & ~mk) | ((v + 1) & mk);
  endfunction

  always @(posedge clk) begin
    core_done <= 1'b0;
    if (core_req) begin
      req_cnt <= req_cnt + 1;
      cm_text <= core_text;
      cm_dec  <= core_decrypt;
      cm_cnt  <= LAT;
    end else if (cm_cnt > 0) begin
      cm_cnt <= cm_cnt - 1;
      if (cm_cnt == 1) begin
        core_done   <= 1'b1;
        core_result <= cm_dec ? pdec(cm_text) : penc(cm_text);
      end
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] m, input logic d, input logic [2:0] w, input logic [127:0] s);
    @(negedge clk);
    cfg_load = 1; cfg_mode = m; cfg_decrypt = d; cfg_ctr_width = w; cfg_seed = s;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic xfer(input string req, input logic [127:0] d, input logic [127:0] exp, input int stall);
    int r0;
    @(negedge clk);
    r0 = req_cnt;
    in_valid = 1; in_data = d;
    @(negedge clk);
    in_valid = 0;
    while (!out_valid) @(negedge clk);
    for (int i = 0; i < stall; i++) begin
      check("R9 in_ready low while output held", {127'b0, in_ready}, 128'h0);
      check("R9 out_data stable", out_data, exp);
      @(negedge clk);
    end
    check(req, out_data, exp);
    check("R10 one core request per block", 128'(req_cnt - r0), 128'h1);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic t_reset;
    check("R1 in_ready", {127'b0, in_ready}, 128'h1);
    check("R1 out_valid", {127'b0, out_valid}, 128'h0);
    check("R1 core_req", {127'b0, core_req}, 128'h0);
    check("R1 load_err", {127'b0, load_err}, 128'h0);
  endtask

  task automatic t_ecb;
    logic [127:0] p = 128'h00112233_44556677_8899aabb_ccddeeff;
    load(3'd0, 0, 0, 128'h0);
    xfer("R2 ecb encrypt", p, penc(p), 0);
    load(3'd0, 1, 0, 128'h0);
    xfer("R2 ecb decrypt", penc(p), p, 2);
    load(3'd6, 0, 0, 128'h5);
    xfer("R2 mode 6 as codebook", p, penc(p), 0);
  endtask

  task automatic t_cbc;
    logic [127:0] iv = 128'hdeadbeef_01234567_89abcdef_cafef00d;
    logic [127:0] p0 = 128'h1, p1 = 128'h2222_0000_ffff, c0, c1;
    c0 = penc(p0 ^ iv); c1 = penc(p1 ^ c0);
    load(3'd1, 0, 0, iv);
    xfer("R3 cbc enc block0", p0, c0, 0);
    xfer("R3 cbc enc block1", p1, c1, 0);
    load(3'd1, 1, 0, iv);
    xfer("R3 cbc dec block0", c0, p0, 0);
    xfer("R3 cbc dec block1", c1, p1, 0);
  endtask

  task automatic t_cfb;
    logic [127:0] iv = 128'h0badc0de_0badc0de_0badc0de_0badc0de;
    logic [127:0] p0 = 128'h55, p1 = 128'haa00aa, c0, c1;
    c0 = penc(iv) ^ p0; c1 = penc(c0) ^ p1;
    load(3'd2, 0, 0, iv);
    xfer("R4 cfb enc block0", p0, c0, 0);
    xfer("R4 cfb enc block1", p1, c1, 0);
    load(3'd2, 1, 0, iv);
    xfer("R4 cfb dec block0", c0, p0, 0);
    xfer("R4 cfb dec block1", c1, p1, 0);
  endtask

  task automatic t_ctr(input logic [2:0] w, input int m, input logic [127:0] seed);
    logic [127:0] c1, d0 = 128'h1234, d1 = 128'h5678;
    c1 = ctr_inc(seed, m);
    load(3'd3, w[0], w, seed);
    xfer("R6 ctr block0", d0, d0 ^ penc(seed), 0);
    xfer("R5 ctr wrap within width", d1, d1 ^ penc(c1), 0);
  endtask

  task automatic t_xts;
    logic [127:0] t0 = 128'h80000000_00000000_00000000_00000001, t1;
    logic [127:0] p0 = 128'hfeed, p1 = 128'hbeef, c0, c1;
    t1 = gfx(t0);
    c0 = penc(p0 ^ t0) ^ t0; c1 = penc(p1 ^ t1) ^ t1;
    load(3'd4, 0, 0, t0);
    xfer("R7 tweak enc block0", p0, c0, 0);
    xfer("R7 tweak enc block1 reduced", p1, c1, 0);
    load(3'd4, 1, 0, t0);
    xfer("R7 tweak dec block0", c0, p0, 0);
    xfer("R7 tweak dec block1", c1, p1, 0);
  endtask

  task automatic t_busy_load;
    logic [127:0] seed = 128'h10, d = 128'h99;
    load(3'd3, 0, 0, seed);
    @(negedge clk);
    in_valid = 1; in_data = d;
    @(negedge clk);
    in_valid = 0;
    check("R9 in_ready low in flight", {127'b0, in_ready}, 128'h0);
    cfg_load = 1; cfg_mode = 3'd0; cfg_seed = 128'hffff;
    @(negedge clk);
    cfg_load = 0;
    check("R8 load_err raised", {127'b0, load_err}, 128'h1);
    @(negedge clk);
    check("R8 load_err one cycle", {127'b0, load_err}, 128'h0);
    while (!out_valid) @(negedge clk);
    check("R8 busy load ignored", out_data, d ^ penc(seed));
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    xfer("R8 chain kept after refused load", d, d ^ penc(seed + 1), 0);
  endtask

  task automatic t_load_wins;
    logic [127:0] d = 128'h4242;
    @(negedge clk);
    cfg_load = 1; cfg_mode = 3'd0; cfg_decrypt = 1; cfg_seed = 0;
    in_valid = 1; in_data = d;
    #1;
    check("R11 in_ready low during load", {127'b0, in_ready}, 128'h0);
    @(negedge clk);
    cfg_load = 0;
    check("R11 no error for idle load", {127'b0, load_err}, 128'h0);
    @(negedge clk);
    in_valid = 0;
    while (!out_valid) @(negedge clk);
    check("R11 block uses new config", out_data, pdec(d));
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ecb();
    t_cbc();
    t_cfb();
    t_ctr(3'd0, 16, 128'h11112222_33334444_55556666_7777ffff);
    t_ctr(3'd1, 32, 128'haaaaaaaa_bbbbbbbb_cccccccc_ffffffff);
    t_ctr(3'd2, 64, 128'h01010101_fffffffe_ffffffff_ffffffff);
    t_ctr(3'd3, 96, 128'h12345678_ffffffff_ffffffff_ffffffff);
    t_ctr(3'd4, 128, '1);
    t_xts();
    t_busy_load();
    t_load_wins();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule